// File: doc/BRIEF.md
# PRBS Receive Checker

This block sits behind a word aligner on a serial receive path and confirms that the incoming parallel words carry an unbroken pseudo-random binary sequence. It is self-synchronising. The first bits that arrive after alignment fill a history register. Every later bit is then predicted from that history by the selected polynomial and compared with what actually arrived. No pattern generator has to be locked to the far end.

Two status flags report the result.

- `chk_done` rises once a whole sequence period has been checked. It then stays high until the receive reset is applied.
- `chk_err` reports mismatches seen after `chk_done`. Each error raises it for at least three cycles. It drops only at a period boundary that closes a clean period.

When a fixed square-wave pattern is selected, the checker does nothing and both flags stay low.

Top module: `prbs_rx_checker`

## Requirements
- R1: While `rx_rst` is high and in the cycle after it is released, `chk_done` and `chk_err` are low.
- R2: `pat_sel` encodes the mode as follows. 0 selects x^7+x^6+1, 1 selects x^10+x^7+1 and 2 selects x^23+x^18+1. 3 is the high-frequency square wave, 4 is the low-frequency square wave, and 5 to 7 are reserved. For every PRBS mode, `rx_word` bit 0 is the earliest bit and each bit equals the XOR of the bits X and T positions earlier.
- R3: Words presented with `word_ok` low are ignored. Such a word restarts seeding and the period count. Once aligned words resume and are correct, no error is reported.
- R4: The first X bits after alignment only seed the history. The period count begins with the first word in which every bit can be predicted, which is aligned word index ceil(X/W).
- R5: `chk_done` goes high in the cycle after aligned word index ceil(X/W)+ceil((2^X−1)/W)−1 and not earlier.
- R6: Once high, `chk_done` stays high until `rx_rst`, through errors and through loss of alignment.
- R7: Mismatches in words taken before `chk_done` was high never raise `chk_err`.
- R8: After `chk_done`, a word containing a mismatch raises `chk_err` in the next cycle. The flag then holds for at least three cycles.
- R9: Period boundaries are counted in words, and a word that crosses a boundary belongs to the closing period. `chk_err` clears at the boundary that ends the first error-free period after the last error.
- R10: In modes 3 to 7 both flags stay low whatever data arrives.
- R11: `rx_rst` clears both flags, the history and the period count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive word clock |
| rx_rst | input | 1 | Synchronous active-high receive reset |
| pat_sel | input | 3 | Pattern mode, encoded per R2 |
| word_ok | input | 1 | Word boundary valid, from the external aligner |
| rx_word | input | DATA_W | Received parallel word, bit 0 earliest |
| chk_done | output | 1 | Sticky full-period-received flag |
| chk_err | output | 1 | Bit-error status flag |

## Verification
The properties check on every cycle that the done flag is sticky and that the error flag never rises while done is low. They also check that the error flag is held for at least three cycles, that it falls only at a period boundary, and that the flags are quiet in fixed modes and after reset. Only the bench scenarios can show the exact word on which done rises for each polynomial. The same goes for the exact boundary at which a clean period clears the error, and for correct prediction after seeding from arbitrary data.

// File: rtl/prbs_chk_pkg.sv
package prbs_chk_pkg;

    localparam int HIST_W   = 23;
    localparam int CNT_W    = 23;
    localparam int FILL_W   = 5;
    localparam int FILL_CAP = 31;

    localparam logic [2:0] MODE_P7  = 3'd0;
    localparam logic [2:0] MODE_P10 = 3'd1;
    localparam logic [2:0] MODE_P23 = 3'd2;

    typedef struct packed {
        logic [HIST_W-1:0] hist;
        logic [FILL_W-1:0] fill;
    } front_s;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             done;
        logic             err;
        logic [1:0]       hold;
        logic             dirty;
    } stat_s;

    // degree of the selected polynomial, 0 for non-PRBS modes
    function automatic int poly_order(input logic [2:0] m);
        case (m)
            MODE_P7:  return 7;
            MODE_P10: return 10;
            MODE_P23: return 23;
            default:  return 0;
        endcase
    endfunction

    function automatic int poly_tap(input logic [2:0] m);
        case (m)
            MODE_P7:  return 6;
            MODE_P10: return 7;
            MODE_P23: return 18;
            default:  return 1;
        endcase
    endfunction

    function automatic logic [CNT_W-1:0] poly_period(input logic [2:0] m);
        logic [31:0] t;
        t = (32'd1 << poly_order(m)) - 32'd1;
        return t[CNT_W-1:0];
    endfunction

endpackage

// File: rtl/prbs_chk_slice.sv
module prbs_chk_slice
    import prbs_chk_pkg::*;
#(
    parameter int DATA_W = 10
) (
    input  logic [HIST_W-1:0] hist_i,
    input  logic [DATA_W-1:0] word_i,
    input  logic [FILL_W-1:0] fill_i,
    input  logic [2:0]        mode_i,
    output logic [HIST_W-1:0] hist_o,
    output logic              miss_o
);

    // Walk the word bit by bit, earliest first; predict, compare, shift.
    always_comb begin
        logic [HIST_W-1:0] h;
        logic [4:0]        idx_a;
        logic [4:0]        idx_b;
        logic              pred;
        int                ord;
        ord    = poly_order(mode_i);
        idx_a  = (ord > 0) ? 5'(ord - 1) : 5'd0;
        idx_b  = 5'(poly_tap(mode_i) - 1);
        h      = hist_i;
        miss_o = 1'b0;
        for (int i = 0; i < DATA_W; i++) begin
            pred = h[idx_a] ^ h[idx_b];
            if ((ord > 0) && (int'(fill_i) + i >= ord) && (word_i[i] != pred)) begin
                miss_o = 1'b1;
            end
            h = {h[HIST_W-2:0], word_i[i]};
        end
        hist_o = h;
    end

endmodule

// File: rtl/prbs_chk_status.sv
module prbs_chk_status
    import prbs_chk_pkg::*;
#(
    parameter int DATA_W = 10
) (
    input  logic       clk,
    input  logic       rx_rst,
    input  logic [2:0] mode_i,
    input  logic       word_ok_i,
    input  logic       step_i,
    input  logic       miss_i,
    output logic       done_o,
    output logic       err_o
);

    localparam logic [CNT_W:0] STEP = (CNT_W + 1)'(DATA_W);

    stat_s            st_q, st_d;
    logic             prbs_on;
    logic [CNT_W-1:0] period;
    logic [CNT_W:0]   sum;
    logic             boundary;
    logic             hit;
    logic             closing_dirty;

    always_comb begin
        prbs_on       = (poly_order(mode_i) != 0);
        period        = poly_period(mode_i);
        sum           = {1'b0, st_q.cnt} + STEP;
        boundary      = prbs_on && word_ok_i && step_i && (sum >= {1'b0, period});
        hit           = prbs_on && word_ok_i && miss_i && st_q.done;
        closing_dirty = st_q.dirty | hit;

        st_d = st_q;
        if (st_q.hold != 2'd0) begin
            st_d.hold = st_q.hold - 2'd1;
        end
        if (!word_ok_i) begin
            st_d.cnt = '0;
        end else if (step_i) begin
            st_d.cnt = boundary ? CNT_W'(sum - {1'b0, period}) : sum[CNT_W-1:0];
        end
        if (boundary) begin
            st_d.done  = 1'b1;
            st_d.dirty = 1'b0;
            if (st_q.err && !closing_dirty && (st_q.hold == 2'd0)) begin
                st_d.err = 1'b0;
            end
        end else begin
            st_d.dirty = closing_dirty;
        end
        if (hit) begin
            st_d.err  = 1'b1;
            st_d.hold = 2'd2;
        end
        if (!prbs_on) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rx_rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign done_o = st_q.done;
    assign err_o  = st_q.err;

    a_r6_done_sticky: assert property (@(posedge clk) disable iff (rx_rst)
        (st_q.done && prbs_on) |=> st_q.done);

    a_r7_err_needs_done: assert property (@(posedge clk) disable iff (rx_rst)
        $rose(st_q.err) |-> $past(st_q.done));

    a_r8_err_min_width: assert property (@(posedge clk) disable iff (rx_rst)
        ($fell(st_q.err) && !$past(rx_rst) && $past(prbs_on))
            |-> ($past(st_q.err, 2) && $past(st_q.err, 3)));

    a_r9_err_clears_at_bound: assert property (@(posedge clk) disable iff (rx_rst)
        ($fell(st_q.err) && !$past(rx_rst) && $past(prbs_on)) |-> $past(boundary));

    a_r10_fixed_quiet: assert property (@(posedge clk) disable iff (rx_rst)
        !$past(prbs_on) |-> (!st_q.done && !st_q.err));

    a_r11_reset_clears: assert property (@(posedge clk)
        $past(rx_rst) |-> (!st_q.done && !st_q.err));

endmodule

// File: rtl/prbs_rx_checker.sv
module prbs_rx_checker
    import prbs_chk_pkg::*;
#(
    parameter int DATA_W = 10
) (
    input  logic              clk,
    input  logic              rx_rst,
    input  logic [2:0]        pat_sel,
    input  logic              word_ok,
    input  logic [DATA_W-1:0] rx_word,
    output logic              chk_done,
    output logic              chk_err
);

    front_s            fr_q, fr_d;
    logic [HIST_W-1:0] hist_nx;
    logic              miss;
    logic              step;

    prbs_chk_slice #(.DATA_W(DATA_W)) u_slice (
        .hist_i (fr_q.hist),
        .word_i (rx_word),
        .fill_i (fr_q.fill),
        .mode_i (pat_sel),
        .hist_o (hist_nx),
        .miss_o (miss)
    );

    // history and seed fill; loss of alignment restarts seeding
    always_comb begin
        fr_d = fr_q;
        if (word_ok) begin
            fr_d.hist = hist_nx;
            fr_d.fill = (int'(fr_q.fill) + DATA_W > FILL_CAP) ?
                        FILL_W'(FILL_CAP) : FILL_W'(int'(fr_q.fill) + DATA_W);
        end else begin
            fr_d.fill = '0;
        end
        step = word_ok && (poly_order(pat_sel) != 0) &&
               (int'(fr_q.fill) >= poly_order(pat_sel));
    end

    always_ff @(posedge clk) begin
        if (rx_rst) begin
            fr_q <= '0;
        end else begin
            fr_q <= fr_d;
        end
    end

    prbs_chk_status #(.DATA_W(DATA_W)) u_status (
        .clk       (clk),
        .rx_rst    (rx_rst),
        .mode_i    (pat_sel),
        .word_ok_i (word_ok),
        .step_i    (step),
        .miss_i    (miss),
        .done_o    (chk_done),
        .err_o     (chk_err)
    );

    a_r3_no_step_unaligned: assert property (@(posedge clk) disable iff (rx_rst)
        !$past(word_ok) |-> (fr_q.fill == '0));

endmodule

// File: tb/prbs_rx_checker_tb.sv
module prbs_rx_checker_tb;

    localparam int W = 10;

    logic         clk = 1'b0;
    logic         rx_rst;
    logic [2:0]   pat_sel;
    logic         word_ok;
    logic [W-1:0] rx_word;
    logic         chk_done;
    logic         chk_err;

    int           n_chk = 0;
    int           n_bad = 0;
    bit           finished = 0;
    logic [22:0]  gh;
    int           ord;
    int           tp;
    int           kw;

    always #4 clk = ~clk;

    prbs_rx_checker #(.DATA_W(W)) u_dut (
        .clk      (clk),
        .rx_rst   (rx_rst),
        .pat_sel  (pat_sel),
        .word_ok  (word_ok),
        .rx_word  (rx_word),
        .chk_done (chk_done),
        .chk_err  (chk_err)
    );

    task automatic check(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0b expected %0b (word %0d)", req, act, exp, kw);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    task automatic set_mode(input logic [2:0] m);
        pat_sel = m;
        case (m)
            3'd0:    begin ord = 7;  tp = 6;  end
            3'd1:    begin ord = 10; tp = 7;  end
            3'd2:    begin ord = 23; tp = 18; end
            default: begin ord = 0;  tp = 1;  end
        endcase
    endtask

    function automatic logic [W-1:0] gen_word();
        logic [W-1:0] w;
        logic         b;
        for (int i = 0; i < W; i++) begin
            b    = gh[ord-1] ^ gh[tp-1];
            w[i] = b;
            gh   = {gh[21:0], b};
        end
        return w;
    endfunction

    function automatic int cdiv(input int a, input int b);
        return (a + b - 1) / b;
    endfunction

    function automatic bit is_bnd(input int k);
        int fc, j, p;
        fc = cdiv(ord, W);
        p  = (1 << ord) - 1;
        if (k < fc) return 1'b0;
        j = k - fc + 1;
        return ((W * j) / p) > ((W * (j - 1)) / p);
    endfunction

    task automatic feed(input logic [W-1:0] w, input logic ok);
        @(negedge clk);
        rx_word = w;
        word_ok = ok;
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rx_rst  = 1'b1;
        word_ok = 1'b0;
        @(posedge clk);
        #1;
        check("R1 done in reset", chk_done, 1'b0);
        check("R1 err in reset", chk_err, 1'b0);
        @(negedge clk);
        rx_rst = 1'b0;
        @(posedge clk);
        #1;
        check("R11 done after reset", chk_done, 1'b0);
        check("R11 err after reset", chk_err, 1'b0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        int d, e, b1, b2;
        logic [W-1:0] w;
        rx_rst  = 1'b1;
        word_ok = 1'b0;
        rx_word = '0;
        kw      = 0;
        set_mode(3'd0);
        gh = 23'h15A5A5;
        do_reset();

        // R3: unaligned garbage is ignored
        for (int i = 0; i < 4; i++) begin
            feed(W'(i * 337 + 91), 1'b0);
            check("R3 unaligned words ignored", chk_done, 1'b0);
        end

        // R4/R5 done timing for x^7, with an ignored early error (R7)
        d = cdiv(ord, W) + cdiv((1 << ord) - 1, W) - 1;
        for (int k = 0; k <= d + 3; k++) begin
            kw = k;
            w  = gen_word();
            if (k == 5) w ^= W'(4);
            feed(w, 1'b1);
            check("R5 done timing (R4 seeding)", chk_done, (k >= d));
            check("R7 early error ignored", chk_err, 1'b0);
        end

        // R8/R9 error rise, hold and clean-period clear
        e  = d + 6;
        b1 = e;
        while (!is_bnd(b1)) b1++;
        b2 = b1 + 1;
        while (!is_bnd(b2)) b2++;
        for (int k = d + 4; k <= b2 + 2; k++) begin
            kw = k;
            w  = gen_word();
            if (k == e) w ^= W'(4);
            feed(w, 1'b1);
            if (k < e)           check("R8 no error before injection", chk_err, 1'b0);
            else if (k <= e + 2) check("R8 error raised and held", chk_err, 1'b1);
            else if (k < b2)     check("R9 error held until clean period", chk_err, 1'b1);
            else                 check("R9 error cleared after clean period", chk_err, 1'b0);
            check("R6 done sticky through error", chk_done, 1'b1);
        end

        // R6/R3 alignment loss keeps done; resumed data raises no error
        for (int i = 0; i < 3; i++) begin
            feed(W'(i * 5 + 1), 1'b0);
            check("R6 done sticky unaligned", chk_done, 1'b1);
        end
        for (int i = 0; i < 30; i++) begin
            w = gen_word();
            feed(w, 1'b1);
            check("R3 reseed after realign no error", chk_err, 1'b0);
        end
        check("R6 done still high", chk_done, 1'b1);

        // R11 reset clears state
        do_reset();
        for (int i = 0; i < 5; i++) begin
            w = gen_word();
            feed(w, 1'b1);
            check("R11 done low after reset", chk_done, 1'b0);
        end

        // R2/R5/R8 x^10 polynomial
        set_mode(3'd1);
        gh = 23'h0ABCDE;
        do_reset();
        d = cdiv(ord, W) + cdiv((1 << ord) - 1, W) - 1;
        for (int k = 0; k <= d + 5; k++) begin
            kw = k;
            w  = gen_word();
            if (k == d + 3) w ^= W'(1);
            feed(w, 1'b1);
            check("R5 done timing x^10", chk_done, (k >= d));
            if (k >= d + 3) check("R8 error raised x^10", chk_err, 1'b1);
            else            check("R2 x^10 clean data no error", chk_err, 1'b0);
        end

        // R10 fixed and reserved modes stay quiet
        set_mode(3'd3);
        do_reset();
        for (int i = 0; i < 200; i++) begin
            feed(10'b1010101010, 1'b1);
            if (i % 50 == 49) begin
                check("R10 high-freq done low", chk_done, 1'b0);
                check("R10 high-freq err low", chk_err, 1'b0);
            end
        end
        set_mode(3'd4);
        for (int i = 0; i < 200; i++) begin
            feed(10'b1111100000, 1'b1);
            if (i % 50 == 49) check("R10 low-freq flags low", chk_done | chk_err, 1'b0);
        end
        set_mode(3'd6);
        for (int i = 0; i < 100; i++) begin
            feed(W'(i * 71), 1'b1);
        end
        check("R10 reserved mode flags low", chk_done | chk_err, 1'b0);

        // R5 x^23: long period, no early done
        set_mode(3'd2);
        gh = 23'h7FFFFF;
        do_reset();
        for (int i = 0; i < 400; i++) begin
            w = gen_word();
            feed(w, 1'b1);
        end
        check("R5 x^23 no early done", chk_done, 1'b0);
        check("R5 x^23 clean data no error", chk_err, 1'b0);

        finished = 1;
        summary();
        $finish;
    end

endmodule